// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Threshold Unit

This block sits beside the storage array and pointer logic of a dual-clock FIFO. It holds two threshold offsets: one measured up from empty (n) and one measured down from full (m). From them and the word counts each clock domain already sees, it produces the two active-low early-warning flags. Software or a host controller programs both offsets over the FIFO's own write data bus. It raises a load strobe, and each enabled write-clock edge then goes to the next offset register. The empty offset is loaded first, then the full offset, and the order repeats. With the load strobe and the read enable both active, each read-clock edge returns the offsets on a readback bus in the same order.

A mode input chooses how the flags are generated. In registered mode, the almost-empty flag is captured only on read-clock edges and the almost-full flag only on write-clock edges. In combinational mode, both flags follow the counts directly. The comparison uses only as many low bits of each offset as the FIFO address needs. Both offsets come up at 127 when they have never been programmed.

Top module: `afo_unit`

## Requirements
- R1: While reset is active and straight after it, both offsets read back as 127. Both the write selector and the read selector point at the empty offset. The readback bus is 0. In registered mode, `ae_n` is 0 and `af_n` is 1.
- R2: Each write-clock edge with `load_n`=0 and `wen_n`=0 stores `wdata` into the selected offset and moves the write selector to the other offset. The first write after reset goes to the empty offset, the second to the full offset, the third to the empty offset again.
- R3: A write-clock edge with `load_n`=0 and `wen_n`=1 changes neither offset nor the write selector. A write-clock edge with `load_n`=1 also leaves both unchanged, whatever `wen_n` is.
- R4: Each read-clock edge with `load_n`=0 and `ren_n`=0 puts the selected offset (all OFS_W bits) on `rdback` and moves the read selector to the other offset. The order is empty, then full, repeating. On any other read-clock edge, `rdback` holds its value.
- R5: The almost-empty condition is true (`ae_n`=0) when `rd_count` is less than or equal to the effective empty offset. This includes a count of 0.
- R6: The almost-full condition is true (`af_n`=0) when `wr_count` is greater than or equal to DEPTH minus the effective full offset. This includes a count of DEPTH.
- R7: The effective offset is the stored offset modulo DEPTH = 2^ADDR_W. Only its ADDR_W low bits take part in the comparison. The readback still returns the full stored value.
- R8: With `sync_mode`=1, `ae_n` shows the almost-empty condition as sampled at the latest read-clock edge. `af_n` shows the almost-full condition as sampled at the latest write-clock edge.
- R9: With `sync_mode`=0, both flags follow the current counts and offsets with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_mode | input | 1 | 1 = registered flags, 0 = combinational flags |
| load_n | input | 1 | Offset access strobe, active low |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| wdata | input | OFS_W | Write data bus carrying offset values |
| wr_count | input | ADDR_W+1 | Stored word count as seen by the write domain |
| rd_count | input | ADDR_W+1 | Stored word count as seen by the read domain |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |
| rdback | output | OFS_W | Offset readback word |

## Verification
The bench builds the unit with ADDR_W=6, so DEPTH is 64, and OFS_W=16. At that depth, the default offset of 127 becomes an effective 63. The almost-full threshold then falls to a single word, and a full sweep of counts from 0 to 64 covers every boundary of both comparisons in a few hundred cycles. Offsets of 69 and 66 check the truncation, because only their low six bits (5 and 2) may reach the comparison while readback returns the whole value. The two clocks run at the same rate with a fixed phase offset. Flags are sampled between the write edge and the read edge, which separates registered behaviour from combinational behaviour.

// File: rtl/afo_pkg.sv
package afo_pkg;

  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } sel_e;

  function automatic sel_e next_sel(input sel_e cur);
    return (cur == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction

  // keep only the low aw bits of a programmed offset
  function automatic logic [31:0] eff_ofs(input logic [31:0] raw, input int unsigned aw);
    logic [31:0] mask;
    mask = (32'd1 << aw) - 32'd1;
    return raw & mask;
  endfunction

  // count at or below the empty-side offset
  function automatic logic ae_hit_f(input logic [31:0] cnt, input logic [31:0] ofs);
    return cnt <= ofs;
  endfunction

  // count within ofs words of depth, written without subtraction
  function automatic logic af_hit_f(input logic [31:0] cnt, input logic [31:0] ofs,
                                    input logic [31:0] depth);
    return (cnt + ofs) >= depth;
  endfunction

endpackage

// File: rtl/afo_ofs_bank.sv
module afo_ofs_bank
  import afo_pkg::*;
#(
  parameter int OFS_W   = 16,
  parameter int RST_OFS = 127
) (
  input  logic             wclk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             wen_n,
  input  logic [OFS_W-1:0] wdata,
  output logic [OFS_W-1:0] ofs_n,
  output logic [OFS_W-1:0] ofs_m,
  output sel_e             wsel,
  output logic             wr_strobe
);

  assign wr_strobe = !load_n && !wen_n;

  for (genvar g = 0; g < 2; g++) begin : g_reg
    localparam sel_e MY_SEL = (g == 0) ? SEL_EMPTY : SEL_FULL;
    logic [OFS_W-1:0] q;
    always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n)
        q <= OFS_W'(RST_OFS);
      else if (wr_strobe && (wsel == MY_SEL))
        q <= wdata;
    end
  end

  assign ofs_n = g_reg[0].q;
  assign ofs_m = g_reg[1].q;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n)
      wsel <= SEL_EMPTY;
    else if (wr_strobe)
      wsel <= next_sel(wsel);
  end

endmodule

// File: rtl/afo_readback.sv
module afo_readback
  import afo_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic             rclk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             ren_n,
  input  logic [OFS_W-1:0] ofs_n,
  input  logic [OFS_W-1:0] ofs_m,
  output logic [OFS_W-1:0] rdback,
  output sel_e             rsel,
  output logic             rd_strobe
);

  assign rd_strobe = !load_n && !ren_n;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rdback <= '0;
      rsel   <= SEL_EMPTY;
    end else if (rd_strobe) begin
      rdback <= (rsel == SEL_FULL) ? ofs_m : ofs_n;
      rsel   <= next_sel(rsel);
    end
  end

endmodule

// File: rtl/afo_flag_gen.sv
module afo_flag_gen #(
  parameter bit RST_FLAG_N = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_mode,
  input  logic hit,
  output logic flag_n
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= RST_FLAG_N;
    else
      flag_q <= !hit;
  end

  assign flag_n = sync_mode ? flag_q : !hit;

endmodule

// File: rtl/afo_unit.sv
module afo_unit
  import afo_pkg::*;
#(
  parameter  int ADDR_W  = 13,
  parameter  int OFS_W   = 16,
  parameter  int RST_OFS = 127,
  localparam int CNT_W   = ADDR_W + 1,
  localparam int DEPTH   = 1 << ADDR_W
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             rst_n,
  input  logic             sync_mode,
  input  logic             load_n,
  input  logic             wen_n,
  input  logic             ren_n,
  input  logic [OFS_W-1:0] wdata,
  input  logic [CNT_W-1:0] wr_count,
  input  logic [CNT_W-1:0] rd_count,
  output logic             ae_n,
  output logic             af_n,
  output logic [OFS_W-1:0] rdback
);

  logic [OFS_W-1:0] ofs_n;
  logic [OFS_W-1:0] ofs_m;
  sel_e             wsel;
  sel_e             rsel;
  logic             wr_strobe;
  logic             rd_strobe;
  logic             ae_hit;
  logic             af_hit;

  afo_ofs_bank #(.OFS_W(OFS_W), .RST_OFS(RST_OFS)) u_bank (
    .wclk      (wclk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .wen_n     (wen_n),
    .wdata     (wdata),
    .ofs_n     (ofs_n),
    .ofs_m     (ofs_m),
    .wsel      (wsel),
    .wr_strobe (wr_strobe)
  );

  afo_readback #(.OFS_W(OFS_W)) u_rdbk (
    .rclk      (rclk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .ren_n     (ren_n),
    .ofs_n     (ofs_n),
    .ofs_m     (ofs_m),
    .rdback    (rdback),
    .rsel      (rsel),
    .rd_strobe (rd_strobe)
  );

  assign ae_hit = ae_hit_f(32'(rd_count), eff_ofs(32'(ofs_n), ADDR_W));
  assign af_hit = af_hit_f(32'(wr_count), eff_ofs(32'(ofs_m), ADDR_W), 32'(DEPTH));

  // index 0: almost-empty in the read domain, index 1: almost-full in the write domain
  logic [1:0] clk_v;
  logic [1:0] hit_v;
  logic [1:0] flag_v;
  assign clk_v = {wclk, rclk};
  assign hit_v = {af_hit, ae_hit};

  for (genvar g = 0; g < 2; g++) begin : g_flag
    afo_flag_gen #(.RST_FLAG_N(g == 1)) u_flag (
      .clk       (clk_v[g]),
      .rst_n     (rst_n),
      .sync_mode (sync_mode),
      .hit       (hit_v[g]),
      .flag_n    (flag_v[g])
    );
  end

  assign ae_n = flag_v[0];
  assign af_n = flag_v[1];

endmodule

// File: rtl/afo_chk.sv
module afo_chk #(
  parameter int OFS_W = 16
) (
  input logic             wclk,
  input logic             rclk,
  input logic             rst_n,
  input logic             sync_mode,
  input logic             load_n,
  input logic             wen_n,
  input logic             ren_n,
  input logic             ae_n,
  input logic             af_n,
  input logic [OFS_W-1:0] rdback,
  input logic [OFS_W-1:0] ofs_n,
  input logic [OFS_W-1:0] ofs_m,
  input logic             wsel,
  input logic             rsel,
  input logic             ae_hit,
  input logic             af_hit
);

  logic w_arm;
  logic r_arm;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) w_arm <= 1'b0;
    else        w_arm <= 1'b1;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) r_arm <= 1'b0;
    else        r_arm <= 1'b1;
  end

  p_sel_toggle_r2: assert property (@(posedge wclk) disable iff (!rst_n)
    (!load_n && !wen_n) |=> (wsel != $past(wsel)));

  p_ofs_hold_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    (load_n || wen_n) |=> ($stable(ofs_n) && $stable(ofs_m) && $stable(wsel)));

  p_rdbk_load_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    (!load_n && !ren_n) |=> (rdback == ($past(rsel) ? $past(ofs_m) : $past(ofs_n))));

  p_rdbk_hold_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    (load_n || ren_n) |=> $stable(rdback));

  p_ae_sync_r8: assert property (@(posedge rclk) disable iff (!rst_n)
    (r_arm && sync_mode && $past(sync_mode)) |-> (ae_n == !$past(ae_hit)));

  p_af_sync_r8: assert property (@(posedge wclk) disable iff (!rst_n)
    (w_arm && sync_mode && $past(sync_mode)) |-> (af_n == !$past(af_hit)));

  p_ae_comb_r9: assert property (@(posedge rclk) disable iff (!rst_n)
    !sync_mode |-> (ae_n == !ae_hit));

  p_af_comb_r9: assert property (@(posedge wclk) disable iff (!rst_n)
    !sync_mode |-> (af_n == !af_hit));

endmodule

bind afo_unit afo_chk #(.OFS_W(OFS_W)) u_chk (
  .wclk      (wclk),
  .rclk      (rclk),
  .rst_n     (rst_n),
  .sync_mode (sync_mode),
  .load_n    (load_n),
  .wen_n     (wen_n),
  .ren_n     (ren_n),
  .ae_n      (ae_n),
  .af_n      (af_n),
  .rdback    (rdback),
  .ofs_n     (ofs_n),
  .ofs_m     (ofs_m),
  .wsel      (wsel),
  .rsel      (rsel),
  .ae_hit    (ae_hit),
  .af_hit    (af_hit)
);

// File: tb/sim_afo_unit.sv
`timescale 1ns/1ps
module sim_afo_unit;

  localparam int AW = 6;
  localparam int OW = 16;
  localparam int D  = 1 << AW;

  logic          wclk = 1'b0;
  logic          rclk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sync_mode = 1'b1;
  logic          load_n = 1'b1;
  logic          wen_n = 1'b1;
  logic          ren_n = 1'b1;
  logic [OW-1:0] wdata = '0;
  logic [AW:0]   wr_count = '0;
  logic [AW:0]   rd_count = '0;
  logic          ae_n;
  logic          af_n;
  logic [OW-1:0] rdback;

  afo_unit #(.ADDR_W(AW), .OFS_W(OW), .RST_OFS(127)) u0 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .sync_mode(sync_mode),
    .load_n(load_n), .wen_n(wen_n), .ren_n(ren_n), .wdata(wdata),
    .wr_count(wr_count), .rd_count(rd_count),
    .ae_n(ae_n), .af_n(af_n), .rdback(rdback)
  );

  always #5 wclk = ~wclk;
  initial begin
    #4;
    forever #5 rclk = ~rclk;
  end

  int    errors = 0;
  int    checks = 0;
  bit    active = 0;
  bit    done = 0;
  string tag = "R1";
  int    cur_wc = 0;
  int    cur_rc = 0;

  // behavioural reference state
  int mn = 127, mm = 127, mrb = 0;
  bit mws = 0, mrs = 0;
  bit mae_q = 0, maf_q = 1;

  always @(posedge wclk) begin
    if (!rst_n) begin
      mn = 127; mm = 127; mws = 0; maf_q = 1;
    end else begin
      maf_q = (int'(wr_count) >= D - (mm % D)) ? 1'b0 : 1'b1;
      if (!load_n && !wen_n) begin
        if (!mws) mn = int'(wdata); else mm = int'(wdata);
        mws = !mws;
      end
    end
  end

  always @(posedge rclk) begin
    if (!rst_n) begin
      mrb = 0; mrs = 0; mae_q = 0;
    end else begin
      mae_q = (int'(rd_count) <= (mn % D)) ? 1'b0 : 1'b1;
      if (!load_n && !ren_n) begin
        mrb = mrs ? mm : mn;
        mrs = !mrs;
      end
    end
  end

  function automatic int exp_ae();
    if (sync_mode) return int'(mae_q);
    return (int'(rd_count) <= (mn % D)) ? 0 : 1;
  endfunction

  function automatic int exp_af();
    if (sync_mode) return int'(maf_q);
    return (int'(wr_count) >= D - (mm % D)) ? 0 : 1;
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string side);
    chk({side, " ae_n"}, int'(ae_n), exp_ae());
    chk({side, " af_n"}, int'(af_n), exp_af());
    chk({side, " rdback"}, int'(rdback), mrb);
  endtask

  always begin
    @(posedge wclk); #2;
    if (active && !done) compare_all("wside");
  end

  always begin
    @(posedge rclk); #2;
    if (active && !done) compare_all("rside");
  end

  task automatic apply(input bit ld, input bit we, input bit re, input int wd);
    @(negedge wclk);
    load_n = ld; wen_n = we; ren_n = re; wdata = wd[OW-1:0];
    wr_count = cur_wc[AW:0]; rd_count = cur_rc[AW:0];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) apply(1, 1, 1, 0);
  endtask

  task automatic wr_ofs(input int v);
    apply(0, 0, 1, v);
  endtask

  task automatic rd_ofs();
    apply(0, 1, 0, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge wclk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset values, default offsets of 127 give effective 63 at depth 64
    idle(3);
    @(negedge wclk); rst_n = 1'b1; active = 1;
    tag = "R1";
    idle(3);
    rd_ofs(); rd_ofs(); idle(2);

    // R2: empty, full, empty order on successive loaded writes
    tag = "R2";
    wr_ofs(5); wr_ofs(10); wr_ofs(3); idle(1);
    rd_ofs(); rd_ofs(); idle(2);

    // R3: load with write disabled, and write without load, change nothing
    tag = "R3";
    apply(0, 1, 1, 999); apply(0, 1, 1, 998);
    apply(1, 0, 1, 777); apply(1, 0, 1, 776); idle(1);
    rd_ofs(); rd_ofs(); idle(1);
    wr_ofs(20); idle(1);
    rd_ofs(); rd_ofs(); idle(2);

    // R4: readback order and holding while load is inactive
    tag = "R4";
    rd_ofs(); idle(3);
    apply(1, 1, 0, 0); apply(1, 1, 0, 0);
    rd_ofs(); rd_ofs(); rd_ofs(); idle(2);

    // R5: empty-side boundary sweep, n = 3 and m = 20
    tag = "R5";
    cur_wc = 0;
    for (int i = 0; i <= D; i++) begin
      cur_rc = i; idle(2);
    end

    // R6: full-side boundary sweep
    tag = "R6";
    cur_rc = 0;
    for (int i = 0; i <= D; i++) begin
      cur_wc = i; idle(2);
    end

    // R7: offsets 69 and 66 compare as 5 and 2; readback keeps the full value
    tag = "R7";
    cur_wc = 0; cur_rc = 0; idle(1);
    wr_ofs(69); wr_ofs(66); idle(1);
    rd_ofs(); rd_ofs(); idle(1);
    for (int i = 0; i <= D; i++) begin
      cur_rc = i; cur_wc = D - i; idle(2);
    end

    // R8: counts change every cycle in registered mode
    tag = "R8";
    sync_mode = 1'b1;
    for (int i = 0; i < 24; i++) begin
      cur_rc = (i * 5) % (D + 1);
      cur_wc = (i * 11) % (D + 1);
      idle(1);
    end
    idle(2);

    // R9: combinational mode follows counts between edges
    tag = "R9";
    @(negedge wclk); sync_mode = 1'b0;
    for (int i = 0; i <= D; i++) begin
      cur_rc = i; cur_wc = (i * 7) % (D + 1); idle(1);
    end
    wr_ofs(0); wr_ofs(0);
    for (int i = 0; i < 4; i++) begin
      cur_rc = i; cur_wc = D - i; idle(1);
    end
    idle(2);

    done = 1;
    summary();
    $finish;
  end

endmodule